// File: doc/BRIEF.md
# Memory ECC Error Statistics Counters

This block keeps running tallies of memory error events reported by a memory controller. Each event arrives as a one-cycle strobe that carries its kind (correctable or uncorrectable), the channel it occurred on and the DIMM position inside that channel. Rows are numbered by walking the channels in ascending order. Inside each channel the populated DIMMs are taken in order, so each DIMM gets its own row. The population of each channel comes from a static configuration input.

One event updates three groups of counters in the same cycle:
- a per-row total for each error kind;
- a per-row count split by channel;
- a per-slot count that only looks at the DIMM position and ignores the channel.

The logging enables only decide whether a log-request pulse is produced. Counting happens either way. A panic mode turns an uncorrectable event into a sticky panic output and keeps that event out of the counters. Any counter can be fetched through a registered read port.

A two-state machine governs panic. In `ST_RUN` the panic output is low. The transition `RUN->HALT` is taken on a valid uncorrectable event while the panic enable is set and clear is low. In `ST_HALT` the panic output is high. The state holds `HALT->HALT` until clear gives `HALT->RUN`. Clear in `ST_RUN` keeps `RUN->RUN`.

Top module: `ecc_err_stats`

## Requirements
- R1: Row mapping. Field c of `chan_pop` (bits [c*POP_W +: POP_W]) gives the number of DIMMs populated in channel c. An event on channel ch, DIMM d maps to row = (sum of populations of channels below ch) + d.
- R2: Each valid event that is counted adds one to the per-row total of its kind (CE when `ev_ue`=0, UE when `ev_ue`=1) for its row.
- R3: Each counted event adds one to the per-row, per-channel counter of its kind at its row and its channel. No other per-row, per-channel counter changes.
- R4: Each counted event adds one to the slot counter of its kind indexed by the DIMM position d, whatever the channel.
- R5: One cycle after a valid event, `log_vld` pulses for one cycle only if the enable for that kind is set (`log_ce_en` for CE, `log_ue_en` for UE). With the pulse, `log_ue`, `log_row` and `log_chan` carry the event's kind, row and channel. The enables never change any counter.
- R6: A valid UE that arrives while `panic_en`=1 raises `panic` on the next cycle. `panic` stays high until clear. That UE is not added to any counter. CEs are still counted while panic is high.
- R7: Counters stop at 2^CNT_W-1 instead of wrapping.
- R8: An event is dropped if its channel is at or beyond NUM_CH, or its DIMM index is not below that channel's population. A dropped event changes no counter, produces no log pulse and sets the sticky flag `bad_event`.
- R9: A cycle with `clr`=1 zeroes every counter, `bad_event` and `panic`. An event presented in that same cycle is discarded.
- R10: Read port. Values of `rd_view`:
  - 0: per-row total at row `rd_idx`;
  - 1: per-row, per-channel count at row `rd_idx` and channel `rd_chan`;
  - 2: slot count at slot `rd_idx`;
  - 3: zero.

  `rd_ue` selects the error kind. An out-of-range index reads 0. `rd_data` is valid one cycle after the selection.
- R11: After reset every counter reads 0, and `panic`, `bad_event` and `log_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_vld | input | 1 | Error event strobe |
| ev_ue | input | 1 | Event kind: 1 uncorrectable, 0 correctable |
| ev_chan | input | CH_W | Channel of the event |
| ev_dimm | input | DIMM_W | DIMM position within the channel |
| chan_pop | input | NUM_CH*POP_W | Populated DIMM count per channel |
| log_ce_en | input | 1 | Allow log pulses for CEs |
| log_ue_en | input | 1 | Allow log pulses for UEs |
| panic_en | input | 1 | Panic on UE instead of counting it |
| clr | input | 1 | Clear all counters and flags |
| rd_view | input | 2 | Counter group select |
| rd_ue | input | 1 | Kind select for the read |
| rd_idx | input | ROW_W | Row or slot index for the read |
| rd_chan | input | CH_W | Channel index for group 1 |
| rd_data | output | CNT_W | Counter value, one cycle after selection |
| log_vld | output | 1 | Log request pulse |
| log_ue | output | 1 | Kind of the logged event |
| log_row | output | ROW_W | Row of the logged event |
| log_chan | output | CH_W | Channel of the logged event |
| panic | output | 1 | Sticky panic indication |
| bad_event | output | 1 | Sticky flag for dropped events |

## Verification
The bench sends every channel/DIMM/kind combination under two population maps, including channel and DIMM codes past the valid range. A wrong prefix sum in the row mapping would put counts in the wrong row. An out-of-range event that was not dropped would leak into a neighbouring row or slot. A small counter width lets the bench drive counters to saturation, where a wrapping counter would fall back to zero. Further cases cover a panic UE that is still counted, a panic that releases before clear, and a clear that loses to a simultaneous event; each shows up as a mismatch between the full counter dump and the arithmetic model.

// File: rtl/ecc_stats_pkg.sv
package ecc_stats_pkg;

    typedef enum logic [1:0] {
        VIEW_ROW   = 2'd0,
        VIEW_ROWCH = 2'd1,
        VIEW_SLOT  = 2'd2,
        VIEW_NONE  = 2'd3
    } view_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } guard_state_e;

endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc && q != TOP)
            q <= q + 1'b1;
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && q == TOP) |=> (q == TOP));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

endmodule

// File: rtl/ecc_row_map.sv
module ecc_row_map #(
    parameter int NUM_CH = 3,
    parameter int DPC    = 3,
    parameter int POP_W  = 2,
    parameter int CH_W   = 2,
    parameter int DIMM_W = 2,
    parameter int ROW_W  = 4
) (
    input  logic [CH_W-1:0]         chan,
    input  logic [DIMM_W-1:0]       dimm,
    input  logic [NUM_CH*POP_W-1:0] pop,
    output logic                    ok,
    output logic [ROW_W-1:0]        row
);
    localparam int NUM_ROWS = NUM_CH * DPC;

    always_comb begin
        int base;
        int cur;
        base = 0;
        cur  = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c < int'(chan)) base = base + int'(pop[c*POP_W +: POP_W]);
            if (c == int'(chan)) cur = int'(pop[c*POP_W +: POP_W]);
        end
        ok  = (int'(chan) < NUM_CH) && (int'(dimm) < cur) && (int'(dimm) < DPC)
              && (base + int'(dimm) < NUM_ROWS);
        row = ok ? ROW_W'(base + int'(dimm)) : '0;
    end

endmodule

// File: rtl/ecc_err_stats.sv
module ecc_err_stats
    import ecc_stats_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int DPC      = 3,
    parameter int CNT_W    = 32,
    parameter int NUM_ROWS = NUM_CH * DPC,
    parameter int POP_W    = $clog2(DPC + 1),
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int DIMM_W   = (DPC > 1) ? $clog2(DPC) : 1,
    parameter int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_vld,
    input  logic                    ev_ue,
    input  logic [CH_W-1:0]         ev_chan,
    input  logic [DIMM_W-1:0]       ev_dimm,
    input  logic [NUM_CH*POP_W-1:0] chan_pop,
    input  logic                    log_ce_en,
    input  logic                    log_ue_en,
    input  logic                    panic_en,
    input  logic                    clr,
    input  logic [1:0]              rd_view,
    input  logic                    rd_ue,
    input  logic [ROW_W-1:0]        rd_idx,
    input  logic [CH_W-1:0]         rd_chan,
    output logic [CNT_W-1:0]        rd_data,
    output logic                    log_vld,
    output logic                    log_ue,
    output logic [ROW_W-1:0]        log_row,
    output logic [CH_W-1:0]         log_chan,
    output logic                    panic,
    output logic                    bad_event
);
    logic             map_ok;
    logic [ROW_W-1:0] map_row;

    ecc_row_map #(
        .NUM_CH(NUM_CH), .DPC(DPC), .POP_W(POP_W),
        .CH_W(CH_W), .DIMM_W(DIMM_W), .ROW_W(ROW_W)
    ) map_i (
        .chan(ev_chan), .dimm(ev_dimm), .pop(chan_pop),
        .ok(map_ok), .row(map_row)
    );

    // panic guard state machine
    guard_state_e state_q, state_d;
    logic         ue_trip;

    assign ue_trip = ev_vld && map_ok && ev_ue && panic_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (!clr && ue_trip) state_d = ST_HALT;
            ST_HALT: if (clr)             state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    assign panic = (state_q == ST_HALT);

    // counting
    logic count_ok;
    assign count_ok = ev_vld && !clr && map_ok && !(ev_ue && panic_en);

    logic [CNT_W-1:0] row_q  [2][NUM_ROWS];
    logic [CNT_W-1:0] rc_q   [2][NUM_ROWS][NUM_CH];
    logic [CNT_W-1:0] slot_q [2][DPC];

    for (genvar t = 0; t < 2; t++) begin : g_kind
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            logic row_hit;
            assign row_hit = count_ok && (ev_ue == (t == 1)) && (map_row == ROW_W'(r));
            ecc_sat_cnt #(.W(CNT_W)) row_cnt_i (
                .clk(clk), .rst_n(rst_n), .clr(clr), .inc(row_hit), .q(row_q[t][r])
            );
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
                ecc_sat_cnt #(.W(CNT_W)) rc_cnt_i (
                    .clk(clk), .rst_n(rst_n), .clr(clr),
                    .inc(row_hit && (ev_chan == CH_W'(c))), .q(rc_q[t][r][c])
                );
            end
        end
        for (genvar s = 0; s < DPC; s++) begin : g_slot
            ecc_sat_cnt #(.W(CNT_W)) slot_cnt_i (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .inc(count_ok && (ev_ue == (t == 1)) && (ev_dimm == DIMM_W'(s))),
                .q(slot_q[t][s])
            );
        end
    end

    // log request and invalid flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_vld   <= 1'b0;
            log_ue    <= 1'b0;
            log_row   <= '0;
            log_chan  <= '0;
            bad_event <= 1'b0;
        end else begin
            log_vld  <= ev_vld && !clr && map_ok && (ev_ue ? log_ue_en : log_ce_en);
            log_ue   <= ev_ue;
            log_row  <= map_row;
            log_chan <= ev_chan;
            if (clr)                   bad_event <= 1'b0;
            else if (ev_vld && !map_ok) bad_event <= 1'b1;
        end
    end

    // read port
    logic [CNT_W-1:0] rd_sel;
    always_comb begin
        rd_sel = '0;
        unique case (view_e'(rd_view))
            VIEW_ROW:
                for (int r = 0; r < NUM_ROWS; r++)
                    if (r == int'(rd_idx)) rd_sel = row_q[rd_ue ? 1 : 0][r];
            VIEW_ROWCH:
                for (int r = 0; r < NUM_ROWS; r++)
                    for (int c = 0; c < NUM_CH; c++)
                        if (r == int'(rd_idx) && c == int'(rd_chan))
                            rd_sel = rc_q[rd_ue ? 1 : 0][r][c];
            VIEW_SLOT:
                for (int s = 0; s < DPC; s++)
                    if (s == int'(rd_idx)) rd_sel = slot_q[rd_ue ? 1 : 0][s];
            default: rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_sel;
    end

    // R6
    panic_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_trip && !clr) |=> panic);

    // R6
    panic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (panic && !clr) |=> panic);

    // R8
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_event && !clr) |=> bad_event);

    // R9
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!panic && !bad_event && !log_vld));

    // R5
    log_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_vld || !map_ok) |=> !log_vld);

endmodule

// File: tb/ecc_err_stats_tb.sv
module ecc_err_stats_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int NDPC = 3;
    localparam int NROWS = NCH * NDPC;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_vld = 0, ev_ue = 0;
    logic [1:0] ev_chan = '0, ev_dimm = '0;
    logic [5:0] chan_pop = '0;
    logic log_ce_en = 0, log_ue_en = 0, panic_en = 0, clr = 0;
    logic [1:0] rd_view = '0;
    logic rd_ue = 0;
    logic [3:0] rd_idx = '0;
    logic [1:0] rd_chan = '0;
    logic [CW-1:0] rd_data;
    logic log_vld, log_ue, panic, bad_event;
    logic [3:0] log_row;
    logic [1:0] log_chan;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_err_stats #(.NUM_CH(NCH), .DPC(NDPC), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_ue(ev_ue),
        .ev_chan(ev_chan), .ev_dimm(ev_dimm), .chan_pop(chan_pop),
        .log_ce_en(log_ce_en), .log_ue_en(log_ue_en), .panic_en(panic_en),
        .clr(clr), .rd_view(rd_view), .rd_ue(rd_ue), .rd_idx(rd_idx),
        .rd_chan(rd_chan), .rd_data(rd_data), .log_vld(log_vld),
        .log_ue(log_ue), .log_row(log_row), .log_chan(log_chan),
        .panic(panic), .bad_event(bad_event)
    );

    int n_vec = 0, n_bad = 0;
    int pop [NCH];
    int m_row [2][NROWS];
    int m_rc [2][NROWS][NCH];
    int m_slot [2][NDPC];
    bit m_panic = 0, m_bad = 0;

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pop(int p0, int p1, int p2);
        pop[0] = p0; pop[1] = p1; pop[2] = p2;
        chan_pop = {2'(p2), 2'(p1), 2'(p0)};
    endtask

    task automatic model_zero();
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < NROWS; r++) begin
                m_row[t][r] = 0;
                for (int c = 0; c < NCH; c++) m_rc[t][r][c] = 0;
            end
            for (int s = 0; s < NDPC; s++) m_slot[t][s] = 0;
        end
        m_panic = 0; m_bad = 0;
    endtask

    function automatic int sat(int v);
        return (v < CMAX) ? v + 1 : v;
    endfunction

    task automatic rd(int view, int ue, int idx, int ch, output int val);
        @(negedge clk);
        rd_view = 2'(view); rd_ue = ue[0]; rd_idx = 4'(idx); rd_chan = 2'(ch);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic check_all(string tag);
        int v;
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < NROWS; r++) begin
                rd(0, t, r, 0, v); chk({tag, " R2 row total"}, v, m_row[t][r]);
                for (int c = 0; c < NCH; c++) begin
                    rd(1, t, r, c, v); chk({tag, " R3 row/chan"}, v, m_rc[t][r][c]);
                end
            end
            for (int s = 0; s < NDPC; s++) begin
                rd(2, t, s, 0, v); chk({tag, " R4 slot"}, v, m_slot[t][s]);
            end
        end
        rd(3, 0, 0, 0, v); chk({tag, " R10 view 3"}, v, 0);
        rd(0, 0, NROWS, 0, v); chk({tag, " R10 index past end"}, v, 0);
    endtask

    task automatic fire(int ue, int ch, int d, bit with_clr);
        bit ok; int base, row, exp_log;
        base = 0;
        for (int c = 0; c < NCH; c++) if (c < ch) base += pop[c];
        ok = (ch < NCH) && (d < NDPC);
        if (ok) ok = (d < pop[ch]) && (base + d < NROWS);
        row = base + d;
        @(negedge clk);
        ev_vld = 1; ev_ue = ue[0]; ev_chan = 2'(ch); ev_dimm = 2'(d); clr = with_clr;
        @(negedge clk);
        ev_vld = 0; clr = 0;
        exp_log = 0;
        if (with_clr) begin
            model_zero();
        end else if (!ok) begin
            m_bad = 1;
        end else begin
            exp_log = ue ? int'(log_ue_en) : int'(log_ce_en);
            if (ue != 0 && panic_en) begin
                m_panic = 1;
            end else begin
                m_row[ue][row] = sat(m_row[ue][row]);
                m_rc[ue][row][ch] = sat(m_rc[ue][row][ch]);
                m_slot[ue][d] = sat(m_slot[ue][d]);
            end
        end
        chk("R5 log pulse", int'(log_vld), exp_log);
        if (exp_log != 0) begin
            chk("R5 log kind", int'(log_ue), ue);
            chk("R1 log row", int'(log_row), row);
            chk("R5 log chan", int'(log_chan), ch);
        end
        chk("R6 panic", int'(panic), int'(m_panic));
        chk("R8 bad flag", int'(bad_event), int'(m_bad));
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        model_zero();
        chk("R9 panic cleared", int'(panic), 0);
        chk("R9 flag cleared", int'(bad_event), 0);
    endtask

    task automatic sweep();
        for (int ch = 0; ch < 4; ch++)
            for (int d = 0; d < 4; d++)
                for (int t = 0; t < 2; t++) fire(t, ch, d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        model_zero();
        set_pop(2, 1, 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 panic", int'(panic), 0);
        chk("R11 bad flag", int'(bad_event), 0);
        chk("R11 log", int'(log_vld), 0);
        check_all("R11");

        // R1 R5: sparse population, CE logging only
        log_ce_en = 1; log_ue_en = 0;
        sweep();
        check_all("R1 sparse");

        // R5: swap logging enables, counting continues
        log_ce_en = 0; log_ue_en = 1;
        sweep();
        check_all("R5 swapped");

        // R7: saturate
        for (int i = 0; i < 20; i++) fire(0, 0, 0, 0);
        check_all("R7 saturate");

        // R6: panic mode
        panic_en = 1;
        fire(1, 1, 0, 0);
        fire(0, 1, 0, 0);
        fire(1, 2, 0, 0);
        panic_en = 0;
        fire(1, 2, 0, 0);
        chk("R6 panic held", int'(panic), 1);
        check_all("R6 panic");

        // R9: clear, then clear racing an event
        pulse_clr();
        check_all("R9 cleared");
        log_ce_en = 1; log_ue_en = 1;
        fire(0, 0, 1, 1);
        fire(1, 2, 0, 1);
        check_all("R9 race");

        // R1: full population
        set_pop(3, 3, 3);
        sweep();
        check_all("R1 full");
        fire(1, 3, 0, 0);
        chk("R8 sticky", int'(bad_event), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule